// File: doc/BRIEF.md
# Dual-Domain SPI Register Readback Sequencer

This block is an SPI master for a peripheral whose registers are split between two domains: a converter/gain domain and a demodulator domain. A domain-select output, driven next to the active-low chip-select, tells the peripheral which domain a frame is for. The host issues one request at a time: a write, or a read, for a given domain, 8-bit address and 16-bit value. A write becomes a single 24-bit frame.

The peripheral cannot simply be read. It has a readout mode, set by bit 1 of register 0x00. Each domain has its own copy of that bit, and the copy written is chosen by the domain-select level. In readout mode, a frame sent to an address returns that register's stored value on the serial input and does not update the register. A read request therefore becomes a fixed chain of frames:

1. Turn readout on, demodulator copy first.
2. Send one or more dummy frames to the target address and capture the returned words.
3. Turn readout off, converter copy first.

The request can ask for repeated captures. The block reports whether the captured words disagree.

Top module: `dspi_rdbk_seq`

## Requirements
- R1: Every frame is 24 SCLK periods with chip-select low: 8 address bits, then 16 data bits, most significant bit first. SCLK idles low. The master changes MOSI on falling SCLK edges and samples MISO on rising edges.
- R2: A host write (`req_write`=1) produces exactly one frame carrying the request address and data. During that frame the domain-select pin equals `req_dom` (0 = demodulator, 1 = converter/gain).
- R3: A read first sends address 0x00 with data 0x0002 with domain-select 0, then the same frame with domain-select 1.
- R4: A read then sends the dummy read frames. Each carries the request address, data 0x0000 and domain-select equal to `req_dom`. The last 16 bits sampled from MISO in the first of these frames are returned on `rsp_data`.
- R5: A read ends by sending address 0x00 with data 0x0000 with domain-select 1, then the same frame with domain-select 0. This makes 4 + n frames in total for n dummy frames.
- R6: A host write frame is never sent while either readout-enable copy is set. After a read completes, a later write updates the peripheral register again.
- R7: Domain-select changes only while chip-select is high. Domain-select is stable for at least SETUP_CYC clock cycles before chip-select falls and for at least SETUP_CYC cycles after it rises. SCLK is low whenever chip-select is high.
- R8: `req_ready` is the inverse of `busy`. A request is accepted when `req_valid` and `req_ready` are both high. `busy` stays high from the cycle after acceptance until the whole chain has finished. `rsp_valid` is a one-cycle pulse in the first cycle with `busy` low. The pulse arrives N·(1 + 2·SETUP_CYC + 48·CLK_DIV) cycles after the accepting edge, where N is the number of frames.
- R9: `req_repeat` sets n, the number of dummy read frames; the value 0 is treated as 1. `rsp_mismatch` is 1 when any later capture differs from the first capture. `rsp_data` always holds the first capture. A write responds with `rsp_data` = 0 and `rsp_mismatch` = 0.
- R10: The address is sent unchanged, including bit 7. In the demodulator domain bit 7 selects the sub-unit, so 0xA1 and 0x21 reach different registers.
- R11: During and after reset: chip-select is high, SCLK is low, `busy` is 0, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dom | input | 1 | Target domain, 0 = demodulator, 1 = converter/gain |
| req_addr | input | 8 | Register address |
| req_data | input | 16 | Write data (ignored for reads) |
| req_repeat | input | REP_W | Number of dummy read frames, 0 treated as 1 |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | First captured read value |
| rsp_mismatch | output | 1 | Repeated captures disagreed |
| spi_sclk | output | 1 | Serial clock |
| spi_csn | output | 1 | Active-low chip-select |
| spi_mosi | output | 1 | Serial data to peripheral |
| spi_miso | input | 1 | Serial data from peripheral |
| spi_dom | output | 1 | Domain-select pin |

## Verification
Each frame occupies 1 + 2·SETUP_CYC + 48·CLK_DIV cycles. The bench therefore expects `rsp_valid` exactly N frame periods after the accepting edge and counts falling clock edges to confirm this. It checks `rsp_data` and `rsp_mismatch` on that same sample and confirms one cycle later that the pulse has dropped. A responder sampled on falling clock edges decodes every frame and logs its domain and word, then the bench checks the log frame by frame against the expected chain. MISO is changed only on the falling-clock sample after a falling SCLK, which is at least one cycle before the master samples it on the next rising SCLK.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] RDEN_ADDR = 8'h00;
  localparam logic DOM_DEMOD = 1'b0;
  localparam logic DOM_CONV  = 1'b1;

  typedef enum logic [2:0] {
    STP_WR, STP_EN_DEM, STP_EN_CNV, STP_RD, STP_DIS_CNV, STP_DIS_DEM
  } step_e;

  // readout-enable control value: only bit 1 is meaningful
  function automatic logic [DATA_W-1:0] rden_word(input logic on);
    return on ? 16'h0002 : 16'h0000;
  endfunction

  function automatic logic step_dom(input step_e s, input logic host_dom);
    case (s)
      STP_EN_DEM, STP_DIS_DEM: return DOM_DEMOD;
      STP_EN_CNV, STP_DIS_CNV: return DOM_CONV;
      default:                 return host_dom;
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] step_frame(input step_e s,
                                                    input logic [ADDR_W-1:0] a,
                                                    input logic [DATA_W-1:0] d);
    case (s)
      STP_EN_DEM, STP_EN_CNV:   return {RDEN_ADDR, rden_word(1'b1)};
      STP_DIS_CNV, STP_DIS_DEM: return {RDEN_ADDR, rden_word(1'b0)};
      STP_RD:                   return {a, {DATA_W{1'b0}}};
      default:                  return {a, d};
    endcase
  endfunction

  function automatic step_e step_next(input step_e s);
    case (s)
      STP_EN_DEM:  return STP_EN_CNV;
      STP_EN_CNV:  return STP_RD;
      STP_RD:      return STP_DIS_CNV;
      STP_DIS_CNV: return STP_DIS_DEM;
      default:     return STP_WR;
    endcase
  endfunction

  // clock cycles from one frame start to the next inside a request
  function automatic int frame_cycles(input int setup, input int div);
    return 1 + 2 * setup + 2 * FRAME_W * div;
  endfunction
endpackage

// File: rtl/dspi_phy.sv
module dspi_phy
  import dspi_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int SETUP_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               frm_dom,
  input  logic [FRAME_W-1:0] frm_word,
  output logic               idle,
  output logic               done,
  output logic [DATA_W-1:0]  rx_data,
  output logic               spi_sclk,
  output logic               spi_csn,
  output logic               spi_mosi,
  input  logic               spi_miso,
  output logic               spi_dom
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_MAX = (CLK_DIV > SETUP_CYC) ? CLK_DIV : SETUP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] DIV_END  = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] SET_END  = CNT_W'(SETUP_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_SHIFT, PH_TRAIL} ph_e;

  ph_e                ph;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] tx_sr;
  logic [DATA_W-1:0]  rx_sr;
  logic               sclk_q, csn_q, dom_q;

  // named internal events
  logic half_tick, sclk_rise, sclk_fall, frame_end, lead_end;
  assign half_tick = (ph == PH_SHIFT) && (cnt == DIV_END);
  assign sclk_rise = half_tick && !sclk_q;
  assign sclk_fall = half_tick && sclk_q;
  assign frame_end = sclk_fall && (bit_cnt == LAST_BIT);
  assign lead_end  = (ph == PH_LEAD) && (cnt == SET_END);
  assign done      = (ph == PH_TRAIL) && (cnt == SET_END);
  assign idle      = (ph == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      bit_cnt <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      dom_q   <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph      <= PH_LEAD;
          cnt     <= '0;
          bit_cnt <= '0;
          dom_q   <= frm_dom;
          tx_sr   <= frm_word;
        end
        PH_LEAD: if (lead_end) begin
          ph    <= PH_SHIFT;
          cnt   <= '0;
          csn_q <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_SHIFT: if (half_tick) begin
          cnt <= '0;
          if (sclk_rise) begin
            sclk_q <= 1'b1;
            rx_sr  <= {rx_sr[DATA_W-2:0], spi_miso};
          end else begin
            sclk_q <= 1'b0;
            if (frame_end) begin
              ph    <= PH_TRAIL;
              csn_q <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_TRAIL: if (done) begin
          ph  <= PH_IDLE;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign spi_sclk = sclk_q;
  assign spi_csn  = csn_q;
  assign spi_mosi = tx_sr[FRAME_W-1];
  assign spi_dom  = dom_q;
  assign rx_data  = rx_sr;

  AST_DOM_HELD:    assert property (@(posedge clk) disable iff (!rst_n)
                     !spi_csn |-> $stable(spi_dom)); // R7
  AST_SCLK_PARK:   assert property (@(posedge clk) disable iff (!rst_n)
                     spi_csn |-> !spi_sclk); // R7
  AST_FRAME_BITS:  assert property (@(posedge clk) disable iff (!rst_n)
                     $rose(spi_csn) |-> $past(bit_cnt) == LAST_BIT); // R1
  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
                     (!spi_csn && !$fell(spi_sclk)) |-> $stable(spi_mosi)); // R1
endmodule

// File: rtl/dspi_ctrl.sv
module dspi_ctrl
  import dspi_pkg::*;
#(
  parameter int REP_W     = 3,
  parameter int FRAME_CYC = 103
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_dom,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [REP_W-1:0]   req_repeat,
  output logic               busy,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_mismatch,
  output logic               phy_start,
  output logic               phy_dom,
  output logic [FRAME_W-1:0] phy_word,
  input  logic               phy_idle,
  input  logic               phy_done,
  input  logic [DATA_W-1:0]  phy_rx
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FC_W = $clog2(FRAME_CYC + 1);

  logic              run, inflight;
  step_e             step;
  logic              h_dom;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_data;
  logic [REP_W-1:0]  reps, rd_cnt, rep_eff;
  logic [DATA_W-1:0] first_q;
  logic              mm_q, rsp_q;
  logic              rden_dem, rden_cnv;
  logic [FC_W-1:0]   fr_cnt;

  // named internal events
  logic accept, rd_last, seq_last;
  assign accept    = req_valid && req_ready;
  assign rep_eff   = (req_repeat == '0) ? REP_W'(1) : req_repeat;
  assign rd_last   = ({1'b0, rd_cnt} + 1'b1) == {1'b0, reps};
  assign seq_last  = (step == STP_WR) || (step == STP_DIS_DEM);
  assign phy_start = run && !inflight && phy_idle;
  assign phy_dom   = step_dom(step, h_dom);
  assign phy_word  = step_frame(step, h_addr, h_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      inflight <= 1'b0;
      step     <= STP_WR;
      h_dom    <= 1'b0;
      h_addr   <= '0;
      h_data   <= '0;
      reps     <= '0;
      rd_cnt   <= '0;
      first_q  <= '0;
      mm_q     <= 1'b0;
      rsp_q    <= 1'b0;
      rden_dem <= 1'b0;
      rden_cnv <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      if (accept) begin
        run     <= 1'b1;
        step    <= req_write ? STP_WR : STP_EN_DEM;
        h_dom   <= req_dom;
        h_addr  <= req_addr;
        h_data  <= req_data;
        reps    <= rep_eff;
        rd_cnt  <= '0;
        first_q <= '0;
        mm_q    <= 1'b0;
      end
      if (phy_start) inflight <= 1'b1;
      if (phy_done) begin
        inflight <= 1'b0;
        case (step)
          STP_EN_DEM:  rden_dem <= 1'b1;
          STP_EN_CNV:  rden_cnv <= 1'b1;
          STP_DIS_CNV: rden_cnv <= 1'b0;
          STP_DIS_DEM: rden_dem <= 1'b0;
          STP_RD: begin
            if (rd_cnt == '0) first_q <= phy_rx;
            else if (phy_rx != first_q) mm_q <= 1'b1;
            rd_cnt <= rd_cnt + 1'b1;
          end
          default: ;
        endcase
        if (seq_last) begin
          run   <= 1'b0;
          rsp_q <= 1'b1;
        end else if (step != STP_RD || rd_last) begin
          step <= step_next(step);
        end
      end
    end
  end

  // frame length observer for the assertion below
  always_ff @(posedge clk) begin
    if (!rst_n)         fr_cnt <= '0;
    else if (phy_start) fr_cnt <= '0;
    else                fr_cnt <= fr_cnt + 1'b1;
  end

  assign req_ready    = !run;
  assign busy         = run;
  assign rsp_valid    = rsp_q;
  assign rsp_data     = first_q;
  assign rsp_mismatch = mm_q;

  AST_NO_WR_IN_RDMODE: assert property (@(posedge clk) disable iff (!rst_n)
                         (phy_start && step == STP_WR) |-> (!rden_dem && !rden_cnv)); // R6
  AST_RD_IN_RDMODE:    assert property (@(posedge clk) disable iff (!rst_n)
                         (phy_start && step == STP_RD) |-> (rden_dem && rden_cnv)); // R4
  AST_EN_ORDER:        assert property (@(posedge clk) disable iff (!rst_n)
                         $rose(rden_cnv) |-> rden_dem); // R3
  AST_DIS_ORDER:       assert property (@(posedge clk) disable iff (!rst_n)
                         $fell(rden_dem) |-> !rden_cnv); // R5
  AST_ACCEPT_BUSY:     assert property (@(posedge clk) disable iff (!rst_n)
                         accept |=> busy); // R8
  AST_RSP_AT_END:      assert property (@(posedge clk) disable iff (!rst_n)
                         rsp_valid |-> (!busy && $past(busy))); // R8
  AST_FRAME_LEN:       assert property (@(posedge clk) disable iff (!rst_n)
                         phy_done |-> fr_cnt == FC_W'(FRAME_CYC - 2)); // R7
endmodule

// File: rtl/dspi_rdbk_seq.sv
module dspi_rdbk_seq
  import dspi_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int SETUP_CYC = 3,
  parameter int REP_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_dom,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [REP_W-1:0]  req_repeat,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_mismatch,
  output logic              spi_sclk,
  output logic              spi_csn,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_dom
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FRAME_CYC = frame_cycles(SETUP_CYC, CLK_DIV);

  logic               phy_start, phy_dom, phy_idle, phy_done;
  logic [FRAME_W-1:0] phy_word;
  logic [DATA_W-1:0]  phy_rx;

  dspi_ctrl #(.REP_W(REP_W), .FRAME_CYC(FRAME_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dom(req_dom), .req_addr(req_addr), .req_data(req_data),
    .req_repeat(req_repeat), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_mismatch(rsp_mismatch),
    .phy_start(phy_start), .phy_dom(phy_dom), .phy_word(phy_word),
    .phy_idle(phy_idle), .phy_done(phy_done), .phy_rx(phy_rx)
  );

  dspi_phy #(.CLK_DIV(CLK_DIV), .SETUP_CYC(SETUP_CYC)) u_phy (
    .clk(clk), .rst_n(rst_n),
    .start(phy_start), .frm_dom(phy_dom), .frm_word(phy_word),
    .idle(phy_idle), .done(phy_done), .rx_data(phy_rx),
    .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_dom(spi_dom)
  );
endmodule

// File: tb/dspi_rdbk_seq_tb.sv
module dspi_rdbk_seq_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int D = 2;
  localparam int S = 3;
  localparam int REP_W = 3;
  localparam int FRAME_P = 1 + 2 * S + 48 * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_dom = 1'b0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [REP_W-1:0] req_repeat = '0;
  logic req_ready, busy, rsp_valid, rsp_mismatch;
  logic [15:0] rsp_data;
  logic spi_sclk, spi_csn, spi_mosi, spi_dom;
  logic miso = 1'b0;

  always #2.5 clk = ~clk;

  dspi_rdbk_seq #(.CLK_DIV(D), .SETUP_CYC(S), .REP_W(REP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dom(req_dom), .req_addr(req_addr),
    .req_data(req_data), .req_repeat(req_repeat), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_mismatch(rsp_mismatch),
    .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
    .spi_miso(miso), .spi_dom(spi_dom)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // ---------------- peripheral responder (sampled on falling clk) --------
  logic [15:0] mem_dem [256];
  logic [15:0] mem_cnv [256];
  logic en_dem, en_cnv;
  logic [24:0] log_fr [256];
  int nfr, rd_tot, glitch_at;
  int bad_bits, wr_viol, mon_viol;
  logic pcsn, psclk, pdom, fdom;
  logic [23:0] rxw;
  logic [15:0] out_val;
  int nb, nf, dom_age, rise_age;

  initial glitch_at = -1;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin mem_dem[i] = '0; mem_cnv[i] = '0; end
      en_dem = 0; en_cnv = 0; nfr = 0; rd_tot = 0;
      bad_bits = 0; wr_viol = 0; mon_viol = 0;
      pcsn = 1; psclk = 0; pdom = 0; fdom = 0; rxw = '0; out_val = '0;
      nb = 0; nf = 0; dom_age = 0; rise_age = 100;
      miso = 0;
    end else begin
      // R7 pin discipline monitor
      if (spi_csn && spi_sclk) mon_viol++;
      if (spi_dom != pdom) begin
        if (!spi_csn || rise_age < S) mon_viol++;
        dom_age = 0;
      end
      if (pcsn && !spi_csn && dom_age < S) mon_viol++;
      if (!pcsn && spi_csn) rise_age = 0;
      // frame decode
      if (pcsn && !spi_csn) begin
        nb = 0; nf = 0; rxw = '0; fdom = spi_dom; out_val = '0; miso = 0;
      end
      if (!spi_csn && !psclk && spi_sclk) begin
        rxw = {rxw[22:0], spi_mosi};
        nb++;
        if (nb == 8 && rxw[7:0] != 8'h00 && (fdom ? en_cnv : en_dem)) begin
          out_val = fdom ? mem_cnv[rxw[7:0]] : mem_dem[rxw[7:0]];
          if (rd_tot == glitch_at) out_val = out_val ^ 16'h0001;
          rd_tot++;
        end
      end
      if (!spi_csn && psclk && !spi_sclk) begin
        nf++;
        if (nf >= 8 && nf <= 23) miso = out_val[23-nf];
      end
      if (!pcsn && spi_csn) begin
        if (nb != 24) bad_bits++;
        log_fr[nfr[7:0]] = {fdom, rxw};
        nfr++;
        if (rxw[23:16] == 8'h00) begin
          if (fdom) en_cnv = rxw[1]; else en_dem = rxw[1];
        end else if (!(fdom ? en_cnv : en_dem)) begin
          if (fdom) mem_cnv[rxw[23:16]] = rxw[15:0];
          else      mem_dem[rxw[23:16]] = rxw[15:0];
        end else if (rxw[15:0] != 16'h0000) begin
          wr_viol++;
        end
      end
      if (dom_age < 1000) dom_age++;
      if (rise_age < 1000) rise_age++;
      pcsn = spi_csn; psclk = spi_sclk; pdom = spi_dom;
    end
  end

  // ---------------- stimulus table ----------------
  typedef struct packed {
    logic        wr;
    logic        dom;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [2:0]  reps;
    logic        glitch;
    logic [15:0] exp;
    logic        exp_mm;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'hA1, 16'h1234, 3'd0, 1'b0, 16'h0000, 1'b0},
    '{1'b1, 1'b1, 8'h05, 16'hAAAA, 3'd0, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 1'b0, 8'hA1, 16'hFFFF, 3'd1, 1'b0, 16'h1234, 1'b0},
    '{1'b0, 1'b1, 8'h05, 16'h0000, 3'd1, 1'b0, 16'hAAAA, 1'b0},
    '{1'b0, 1'b0, 8'h21, 16'h0000, 3'd1, 1'b0, 16'h0000, 1'b0},
    '{1'b1, 1'b0, 8'h21, 16'h5A5A, 3'd0, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 1'b0, 8'h21, 16'h0000, 3'd3, 1'b0, 16'h5A5A, 1'b0},
    '{1'b0, 1'b0, 8'hA1, 16'h0000, 3'd0, 1'b0, 16'h1234, 1'b0},
    '{1'b0, 1'b1, 8'hA1, 16'h0000, 3'd1, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 1'b1, 8'h05, 16'h0000, 3'd2, 1'b1, 16'hAAAA, 1'b1},
    '{1'b1, 1'b1, 8'h05, 16'h0F0F, 3'd0, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 1'b1, 8'h05, 16'h0000, 3'd7, 1'b0, 16'h0F0F, 1'b0}
  };

  task automatic run_vec(input vec_t v);
    int n, reps, cyc, base, exp_cyc;
    reps = (v.reps == 0) ? 1 : int'(v.reps);
    n = v.wr ? 1 : 4 + reps;
    exp_cyc = n * FRAME_P + 1;
    base = nfr;
    glitch_at = v.glitch ? rd_tot + 1 : -1;
    @(negedge clk);
    req_valid = 1; req_write = v.wr; req_dom = v.dom;
    req_addr = v.addr; req_data = v.data; req_repeat = v.reps;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    cyc = 1;
    chk("R8 busy after accept", {31'b0, busy}, 32'd1);
    chk("R8 ready low while busy", {31'b0, req_ready}, 32'd0);
    while (!rsp_valid && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R8 response cycle", cyc, exp_cyc);
    chk("R4 R9 rsp_data", {16'b0, rsp_data}, {16'b0, v.exp});
    chk("R9 rsp_mismatch", {31'b0, rsp_mismatch}, {31'b0, v.exp_mm});
    chk("R8 busy low at response", {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk("R8 rsp_valid one cycle", {31'b0, rsp_valid}, 32'd0);
    chk("R5 R9 frame count", nfr - base, n);
    if (v.wr) begin
      chk("R2 R10 write frame", {7'b0, log_fr[base[7:0]]}, {7'b0, v.dom, v.addr, v.data});
    end else begin
      chk("R3 enable demod first", {7'b0, log_fr[base[7:0]]}, {7'b0, 1'b0, 24'h000002});
      chk("R3 enable conv second", {7'b0, log_fr[8'(base+1)]}, {7'b0, 1'b1, 24'h000002});
      for (int k = 0; k < reps; k++)
        chk("R4 R10 dummy read frame", {7'b0, log_fr[8'(base+2+k)]}, {7'b0, v.dom, v.addr, 16'h0000});
      chk("R5 disable conv first", {7'b0, log_fr[8'(base+2+reps)]}, {7'b0, 1'b1, 24'h000000});
      chk("R5 disable demod last", {7'b0, log_fr[8'(base+3+reps)]}, {7'b0, 1'b0, 24'h000000});
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R11 csn high in reset", {31'b0, spi_csn}, 32'd1);
    chk("R11 sclk low in reset", {31'b0, spi_sclk}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 busy after reset", {31'b0, busy}, 32'd0);
    chk("R11 ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R11 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // directed: a write after reads must still store (R6), read it back
    run_vec('{1'b1, 1'b0, 8'hA1, 16'hC3C3, 3'd0, 1'b0, 16'h0000, 1'b0});
    run_vec('{1'b0, 1'b0, 8'hA1, 16'h0000, 3'd1, 1'b0, 16'hC3C3, 1'b0});
    repeat (10) @(negedge clk);
    chk("R1 frames of 24 bits", bad_bits, 0);
    chk("R6 no storing write in readout mode", wr_viol, 0);
    chk("R7 pin discipline", mon_viol, 0);
    finish_run();
  end

  initial begin
    #(200000 * 5);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule